// File: doc/BRIEF.md
# DDR2 Command Decoder with Bank and Power-State Tracking

This block sits on the device side of a DDR2 SDRAM command bus. Every rising clock edge it samples the chip select, the three command strobes, the bank address, the address bus and the clock enable. It turns each accepted command into a single-cycle decoded strobe that carries the command code, the bank, the address and the auto-precharge flag. It also keeps a map of which of the four banks hold an open row, follows the power state that the clock enable selects, and latches the termination setting written through the extended mode register. Any protocol misuse it sees is reported as a one-cycle violation pulse.

The decoded strobe is a valid-only stream with no ready input. A memory command bus cannot be stalled, so a consumer has to take every strobe in the cycle it appears. A new command may follow in the next cycle. All outputs are registered except `pwr_state`, which leaves self refresh as soon as the clock enable rises.

Top module: `ddr2_cmd_tracker`

## Requirements
- R1: A command is accepted only at an edge where cke is high, cs_n is low and the block is in the normal state. The command code is {ras_n,cas_n,we_n}: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode-register write, 111 no-operation. For every accepted command other than no-operation, cmd_valid is high for exactly the following cycle, with cmd_code, cmd_bank and cmd_addr equal to the sampled values.
- R2: An edge with cs_n high is a deselect. It produces no strobe, no violation and no change to the open-row map, whatever the other command and address lines carry.
- R3: An activate sets bit `ba` of open_map, and cmd_addr carries the row.
- R4: A read or write reports cmd_ap equal to address bit 10. When that bit is 1 and the bank is open, the bank's open_map bit is cleared after the command.
- R5: A precharge with address bit 10 low clears only bank `ba`. With address bit 10 high it clears all four banks.
- R6: An activate to a bank that is already open pulses viol_row_open, and the bank stays open. A read or write to a closed bank pulses viol_no_row and changes nothing.
- R7: Code 110 with cs_n low pulses viol_illegal and produces no strobe.
- R8: In the normal state, an edge with cke low moves pwr_state (00 normal, 01 precharge power-down, 10 active power-down, 11 self refresh) as follows. It goes to 11 when a refresh accompanies that edge and no bank is open. Otherwise it goes to 10 if any bank is open, or to 01 if none is.
- R9: Power-down exit is synchronous: the first edge with cke high returns the state to 00. Commands sampled while in power-down or self refresh, or at the exit edge, are ignored, and open_map is preserved.
- R10: In self refresh, pwr_state shows 00 as soon as cke is high, without waiting for a clock edge.
- R11: A read or write presented with cs_n low and cke low in the normal state pulses viol_cke_access.
- R12: A mode-register write with ba = 01 sets the termination enable to (address bit 2 OR address bit 6). A write to any other ba leaves it unchanged. odt_en is odt_in registered, gated by that enable, which resets to off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge sampling |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Command strobe (row) |
| cas_n | input | 1 | Command strobe (column) |
| we_n | input | 1 | Command strobe (write) |
| ba | input | 2 | Bank address |
| addr | input | 13 | Row / column / opcode address |
| odt_in | input | 1 | Termination request |
| cmd_valid | output | 1 | Decoded command strobe, one cycle |
| cmd_code | output | 3 | Decoded command code |
| cmd_bank | output | 2 | Bank of the decoded command |
| cmd_addr | output | 13 | Address of the decoded command |
| cmd_ap | output | 1 | Auto-precharge flag for read/write |
| open_map | output | 4 | One bit per bank, 1 = row open |
| pwr_state | output | 2 | Power state, encoding in R8 |
| odt_en | output | 1 | Effective termination enable |
| viol_no_row | output | 1 | Access to a closed bank |
| viol_row_open | output | 1 | Activate to an open bank |
| viol_illegal | output | 1 | Reserved command code seen |
| viol_cke_access | output | 1 | Read/write with cke low |

## Verification
The assertions assume that synchronous reset is held for at least one edge and that the inputs are stable around each rising edge. Under those assumptions they can relate every state and strobe to the previous sampled cke and odt_in. They place no limit on command order, because misordered commands are reported as violations and are not treated as excluded stimulus. The random stimulus keeps cke high on about nine cycles in ten, so power-down periods stay short. It drives cs_n low for four cycles in five and draws every code, bank and address value freely. Directed cases cover the power-state entries and exits and the asynchronous self-refresh exit. For that exit, inputs change only at falling edges, except for cke, which rises mid-cycle.

// File: rtl/ddr2_trk_pkg.sv
`timescale 1ns/1ps
package ddr2_trk_pkg;
  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_ILL = 3'b110,
    CMD_NOP = 3'b111
  } cmd_e;

  typedef enum logic [1:0] {
    PWR_ON     = 2'b00,
    PWR_PRE_PD = 2'b01,
    PWR_ACT_PD = 2'b10,
    PWR_SREF   = 2'b11
  } pwr_e;

  function automatic logic is_access(cmd_e c);
    return (c == CMD_RD) || (c == CMD_WR);
  endfunction
endpackage

// File: rtl/ddr2_cmd_decode.sv
`timescale 1ns/1ps
module ddr2_cmd_decode
  import ddr2_trk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd_raw,
  output logic selected,
  output logic legal,
  output logic illegal
);
  assign selected = !cs_n;
  assign cmd_raw  = cmd_e'({ras_n, cas_n, we_n});
  assign legal    = selected && (cmd_raw != CMD_NOP) && (cmd_raw != CMD_ILL);
  assign illegal  = selected && (cmd_raw == CMD_ILL);
endmodule

// File: rtl/ddr2_power_fsm.sv
`timescale 1ns/1ps
module ddr2_power_fsm
  import ddr2_trk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cke,
  input  logic       any_open,
  input  logic       sref_req,
  output logic [1:0] pwr_state,
  output logic       cmd_window
);
  pwr_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PWR_ON: begin
        if (!cke) begin
          if (sref_req && !any_open) st_d = PWR_SREF;
          else if (any_open)         st_d = PWR_ACT_PD;
          else                       st_d = PWR_PRE_PD;
        end
      end
      default: if (cke) st_d = PWR_ON;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= PWR_ON;
    else        st_q <= st_d;
  end

  // self-refresh exit follows cke directly, power-down exit waits for the edge
  assign pwr_state  = (st_q == PWR_SREF && cke) ? PWR_ON : st_q;
  assign cmd_window = (st_q == PWR_ON) && cke;
endmodule

// File: rtl/ddr2_bank_tracker.sv
`timescale 1ns/1ps
module ddr2_bank_tracker
  import ddr2_trk_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int BA_W  = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  cmd_e             cmd,
  input  logic [BA_W-1:0]  ba,
  input  logic             ap,
  output logic [NBANK-1:0] open_map,
  output logic             viol_no_row,
  output logic             viol_row_open
);
  logic [NBANK-1:0] nxt;
  logic             sel_open;

  assign sel_open = open_map[ba];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    localparam logic [BA_W-1:0] IDX = BA_W'(g);
    logic hit;
    assign hit = (ba == IDX);
    assign nxt[g] = !en                                  ? open_map[g] :
                    (cmd == CMD_ACT && hit)              ? 1'b1 :
                    (cmd == CMD_PRE && (ap || hit))      ? 1'b0 :
                    (is_access(cmd) && hit && ap)        ? 1'b0 :
                                                           open_map[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_map      <= '0;
      viol_no_row   <= 1'b0;
      viol_row_open <= 1'b0;
    end else begin
      open_map      <= nxt;
      viol_no_row   <= en && is_access(cmd) && !sel_open;
      viol_row_open <= en && (cmd == CMD_ACT) && sel_open;
    end
  end
endmodule

// File: rtl/ddr2_cmd_tracker.sv
`timescale 1ns/1ps
module ddr2_cmd_tracker
  import ddr2_trk_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int NBANK   = 4,
  parameter int AP_BIT  = 10,
  parameter int EMR_SEL = 1,
  parameter int TERM_LO = 2,
  parameter int TERM_HI = 6,
  localparam int BA_W   = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              odt_in,
  output logic              cmd_valid,
  output logic [2:0]        cmd_code,
  output logic [BA_W-1:0]   cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_ap,
  output logic [NBANK-1:0]  open_map,
  output logic [1:0]        pwr_state,
  output logic              odt_en,
  output logic              viol_no_row,
  output logic              viol_row_open,
  output logic              viol_illegal,
  output logic              viol_cke_access
);
  localparam logic [BA_W-1:0] EMR_BA = BA_W'(EMR_SEL);

  cmd_e cmd_raw;
  logic selected, legal, illegal, cmd_window, take, term_on;

  ddr2_cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cmd_raw(cmd_raw), .selected(selected), .legal(legal), .illegal(illegal)
  );

  ddr2_power_fsm u_pwr (
    .clk(clk), .rst_n(rst_n), .cke(cke),
    .any_open(|open_map),
    .sref_req(selected && cmd_raw == CMD_REF),
    .pwr_state(pwr_state), .cmd_window(cmd_window)
  );

  assign take = cmd_window && legal;

  ddr2_bank_tracker #(.NBANK(NBANK), .BA_W(BA_W)) u_banks (
    .clk(clk), .rst_n(rst_n), .en(take), .cmd(cmd_raw), .ba(ba),
    .ap(addr[AP_BIT]), .open_map(open_map),
    .viol_no_row(viol_no_row), .viol_row_open(viol_row_open)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid       <= 1'b0;
      cmd_code        <= CMD_NOP;
      cmd_bank        <= '0;
      cmd_addr        <= '0;
      cmd_ap          <= 1'b0;
      viol_illegal    <= 1'b0;
      viol_cke_access <= 1'b0;
      term_on         <= 1'b0;
      odt_en          <= 1'b0;
    end else begin
      cmd_valid       <= take;
      viol_illegal    <= cmd_window && illegal;
      viol_cke_access <= selected && is_access(cmd_raw) && !cke &&
                         (pwr_state == PWR_ON);
      odt_en          <= odt_in && term_on;
      if (take) begin
        cmd_code <= cmd_raw;
        cmd_bank <= ba;
        cmd_addr <= addr;
        cmd_ap   <= is_access(cmd_raw) && addr[AP_BIT];
        if (cmd_raw == CMD_MRS && ba == EMR_BA)
          term_on <= addr[TERM_LO] || addr[TERM_HI];
      end
    end
  end
endmodule

// File: rtl/ddr2_cmd_tracker_chk.sv
`timescale 1ns/1ps
module ddr2_cmd_tracker_chk
  import ddr2_trk_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int NBANK  = 4,
  parameter int AP_BIT = 10,
  parameter int BA_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic              odt_in,
  input logic              cmd_valid,
  input logic [2:0]        cmd_code,
  input logic [BA_W-1:0]   cmd_bank,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              cmd_ap,
  input logic [NBANK-1:0]  open_map,
  input logic [1:0]        pwr_state,
  input logic              odt_en,
  input logic              viol_illegal
);
  p_valid_cke_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ($past(cke) && $past(pwr_state) == PWR_ON));

  p_act_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == CMD_ACT) |-> open_map[cmd_bank]);

  p_ap_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_code == CMD_RD || cmd_code == CMD_WR) && cmd_ap)
      |-> !open_map[cmd_bank]);

  p_pre_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == CMD_PRE && cmd_addr[AP_BIT]) |-> (open_map == '0));

  p_no_strobe_ill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    viol_illegal |-> !cmd_valid);

  p_actpd_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == PWR_ACT_PD) |-> (open_map != '0));

  p_prepd_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == PWR_PRE_PD || pwr_state == PWR_SREF) |-> (open_map == '0));

  p_pd_ckelow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == PWR_PRE_PD || pwr_state == PWR_ACT_PD) |-> !$past(cke));

  p_pd_map_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_state) != PWR_ON && pwr_state != PWR_ON) |-> $stable(open_map));

  p_odt_r12: assert property (@(posedge clk) disable iff (!rst_n)
    odt_en |-> $past(odt_in));
endmodule

bind ddr2_cmd_tracker ddr2_cmd_tracker_chk #(
  .ADDR_W(ADDR_W), .NBANK(NBANK), .AP_BIT(AP_BIT), .BA_W(BA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .odt_in(odt_in),
  .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
  .cmd_addr(cmd_addr), .cmd_ap(cmd_ap), .open_map(open_map),
  .pwr_state(pwr_state), .odt_en(odt_en), .viol_illegal(viol_illegal)
);

// File: tb/tb_ddr2_cmd_tracker.sv
`timescale 1ns/1ps
module tb_ddr2_cmd_tracker;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cke, cs_n, ras_n, cas_n, we_n, odt_in;
  logic [1:0] ba;
  logic [12:0] addr;
  logic cmd_valid, cmd_ap, odt_en, viol_no_row, viol_row_open, viol_illegal, viol_cke_access;
  logic [2:0] cmd_code;
  logic [1:0] cmd_bank, pwr_state;
  logic [12:0] cmd_addr;
  logic [3:0] open_map;

  ddr2_cmd_tracker dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .odt_in(odt_in),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .cmd_ap(cmd_ap), .open_map(open_map),
    .pwr_state(pwr_state), .odt_en(odt_en), .viol_no_row(viol_no_row),
    .viol_row_open(viol_row_open), .viol_illegal(viol_illegal),
    .viol_cke_access(viol_cke_access)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference model state and expectations
  logic [3:0]  m_open;
  logic [1:0]  m_pwr;
  logic        m_term;
  logic        e_valid, e_ap, e_vnr, e_vro, e_vill, e_vcke, e_odt;
  logic [2:0]  e_code;
  logic [1:0]  e_bank;
  logic [12:0] e_addr;

  task automatic chk(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic model_step();
    logic [2:0] c;
    logic sel;
    c = {ras_n, cas_n, we_n};
    sel = !cs_n;
    e_valid = 0; e_vnr = 0; e_vro = 0; e_vill = 0; e_vcke = 0; e_ap = 0;
    e_odt = odt_in && m_term;
    if (m_pwr == 2'b00) begin
      if (cke) begin
        if (sel && c != 3'b111 && c != 3'b110) begin
          e_valid = 1; e_code = c; e_bank = ba; e_addr = addr;
          e_ap = (c == 3'b100 || c == 3'b101) && addr[10];
          case (c)
            3'b011: begin if (m_open[ba]) e_vro = 1; m_open[ba] = 1'b1; end
            3'b100, 3'b101: begin
              if (!m_open[ba]) e_vnr = 1;
              else if (addr[10]) m_open[ba] = 1'b0;
            end
            3'b010: if (addr[10]) m_open = '0; else m_open[ba] = 1'b0;
            3'b000: if (ba == 2'd1) m_term = addr[2] | addr[6];
            default: ;
          endcase
        end
        if (sel && c == 3'b110) e_vill = 1;
      end else begin
        if (sel && (c == 3'b100 || c == 3'b101)) e_vcke = 1;
        if (sel && c == 3'b001 && m_open == '0) m_pwr = 2'b11;
        else if (m_open != '0)                 m_pwr = 2'b10;
        else                                   m_pwr = 2'b01;
      end
    end else if (cke) m_pwr = 2'b00;
  endtask

  task automatic compare(input string tag);
    chk({tag, " valid"}, cmd_valid, e_valid);
    if (e_valid) begin
      chk({tag, " code"}, cmd_code, e_code);
      chk({tag, " bank"}, cmd_bank, e_bank);
      chk({tag, " addr"}, cmd_addr, e_addr);
      chk({tag, " ap"}, cmd_ap, e_ap);
    end
    chk({tag, " open_map"}, open_map, m_open);
    chk({tag, " pwr_state"}, pwr_state, m_pwr);
    chk({tag, " viol_no_row"}, viol_no_row, e_vnr);
    chk({tag, " viol_row_open"}, viol_row_open, e_vro);
    chk({tag, " viol_illegal"}, viol_illegal, e_vill);
    chk({tag, " viol_cke_access"}, viol_cke_access, e_vcke);
    chk({tag, " odt_en"}, odt_en, e_odt);
  endtask

  task automatic drive(input logic k, input logic s, input logic [2:0] c,
                       input logic [1:0] b, input logic [12:0] a, input logic o);
    cke = k; cs_n = s; {ras_n, cas_n, we_n} = c; ba = b; addr = a; odt_in = o;
  endtask

  task automatic cyc(input logic k, input logic s, input logic [2:0] c,
                     input logic [1:0] b, input logic [12:0] a, input logic o,
                     input string tag);
    @(negedge clk);
    drive(k, s, c, b, a, o);
    @(posedge clk);
    model_step();
    #2;
    compare(tag);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0;
    drive(1, 1, 3'b111, 0, 0, 0);
    m_open = '0; m_pwr = 2'b00; m_term = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 reset cmd_valid", cmd_valid, 0);
    chk("R8 reset pwr_state", pwr_state, 0);
    chk("R3 reset open_map", open_map, 0);
    chk("R12 reset odt_en", odt_en, 0);

    cyc(1, 1, 3'b011, 2, 13'h0abc, 0, "R2 deselect");
    cyc(1, 0, 3'b011, 2, 13'h0abc, 0, "R3 activate");
    cyc(1, 0, 3'b011, 2, 13'h0123, 0, "R6 act open");
    cyc(1, 0, 3'b101, 1, 13'h0010, 0, "R6 read closed");
    cyc(1, 0, 3'b100, 2, 13'h0405, 0, "R4 write ap");
    cyc(1, 0, 3'b011, 0, 13'h0001, 0, "R3 act b0");
    cyc(1, 0, 3'b011, 3, 13'h0002, 0, "R3 act b3");
    cyc(1, 0, 3'b101, 3, 13'h0007, 0, "R4 read no ap");
    cyc(1, 0, 3'b010, 0, 13'h0000, 0, "R5 pre single");
    cyc(1, 0, 3'b011, 1, 13'h0003, 0, "R3 act b1");
    cyc(1, 0, 3'b010, 2, 13'h0400, 0, "R5 pre all");
    cyc(1, 0, 3'b110, 0, 13'h0000, 0, "R7 illegal");
    cyc(1, 0, 3'b111, 0, 13'h0000, 1, "R1 nop");
    cyc(1, 0, 3'b000, 0, 13'h0044, 1, "R12 mrs bank0");
    cyc(1, 0, 3'b111, 0, 13'h0000, 1, "R12 odt off");
    cyc(1, 0, 3'b000, 1, 13'h0004, 1, "R12 emr on");
    cyc(1, 0, 3'b111, 0, 13'h0000, 1, "R12 odt on");
    cyc(1, 0, 3'b011, 1, 13'h0009, 0, "R3 act b1");
    cyc(0, 0, 3'b111, 0, 13'h0000, 0, "R8 act pd");
    cyc(0, 0, 3'b011, 2, 13'h0000, 0, "R9 ignored in pd");
    cyc(1, 0, 3'b011, 2, 13'h0000, 0, "R9 exit edge");
    cyc(1, 0, 3'b011, 2, 13'h0000, 0, "R9 after exit");
    cyc(1, 0, 3'b010, 0, 13'h0400, 0, "R5 pre all");
    cyc(0, 0, 3'b111, 0, 13'h0000, 0, "R8 pre pd");
    cyc(1, 1, 3'b111, 0, 13'h0000, 0, "R9 pd exit");
    cyc(0, 0, 3'b001, 0, 13'h0000, 0, "R8 sref entry");
    cyc(0, 0, 3'b011, 1, 13'h0000, 0, "R10 sref hold");
    @(negedge clk);
    drive(0, 1, 3'b111, 0, 0, 0);
    #4;
    chk("R10 sref before rise", pwr_state, 3);
    cke = 1'b1;
    #1;
    chk("R10 async exit", pwr_state, 0);
    @(posedge clk);
    model_step();
    #2;
    compare("R10 after exit");
    cyc(1, 0, 3'b011, 0, 13'h0011, 0, "R3 act b0");
    cyc(0, 0, 3'b101, 0, 13'h0011, 0, "R11 read cke low");
    cyc(1, 1, 3'b111, 0, 13'h0000, 0, "R9 exit");

    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom % 10) != 0, ($urandom % 5) == 0, 3'($urandom),
          2'($urandom), 13'($urandom), 1'($urandom), "R1 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule